// File: doc/BRIEF.md
# Two-Wire Byte Write with Acknowledge Polling

This block is a bus master on an open-drain two-wire serial bus. It writes one byte into a memory target and then finds out when the target's internal write has finished. It does not wait a fixed delay. Instead it addresses the target for a write again and again until the target acknowledges. A single request carries the 7-bit device address, the word address and the data byte. The block then runs the whole sequence without further help and ends with a one-clock completion pulse.

The bus lines are driven as pull-down enables: a high output pulls the line low, and a low output releases it. The SCL period comes from a divider. Each bit takes four quarter phases, and each quarter lasts `QTR_CYC` clocks. The number of polls is bounded by `MAX_POLLS`. If the target never answers within that bound, or refuses a byte of the write command itself, the sequence ends with an error flag. Reads, multi-master arbitration and clock stretching are not supported.

Top module: `i2c_wr_poll`

## Requirements
- R1: During and after reset, `busy_o`, `done_o` and `err_o` are low and both line drivers are released (`scl_low_o`=0, `sda_low_o`=0). Whenever `busy_o` is low, both lines stay released.
- R2: `req_i` is taken only while `busy_o` is low, and `busy_o` rises on the next clock. The address and data inputs are captured at that moment. A request while busy, including the cycle in which `done_o` is high, is ignored and starts no bus activity.
- R3: The write command is a START, then the control byte `{dev_addr_i, 1'b0}` (R/W bit in the LSB, 0 = write), then the word address, then the data byte. Every byte is sent MSB first and is followed by a ninth clock in which the master releases SDA. The command ends with a STOP.
- R4: Within a byte, SCL is low for two quarters and high for two quarters, so each high pulse lasts `2*QTR_CYC` clocks. SDA changes only while SCL is low, except at START (SDA falls with SCL high) and STOP (SDA rises with SCL high). After a STOP, SCL stays high until the next START.
- R5: SDA sampled low during the high phase of the ninth clock counts as an acknowledge. SDA sampled high counts as a refusal.
- R6: Polling starts right after the STOP that ends the write command. Each poll is a START followed by the control byte `{dev_addr_i, 1'b0}`. A refused poll is closed with a STOP before the next START.
- R7: An acknowledged poll is closed with a STOP. `done_o` then pulses with `err_o` low, and the block returns to idle.
- R8: At most `MAX_POLLS` polls are issued. If every one of them is refused, the sequence ends with a STOP and `done_o` together with `err_o`. An acknowledge on the last permitted poll counts as success.
- R9: A refusal of any byte of the write command ends the sequence with a STOP and `done_o` together with `err_o`, and no polling takes place.
- R10: `done_o` is high for exactly one clock per sequence, and `err_o` is high only in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a write-and-poll sequence |
| dev_addr_i | input | 7 | Target device address |
| word_addr_i | input | 8 | Memory word address |
| wr_data_i | input | 8 | Data byte to write |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_low_o | output | 1 | Pull SCL low when high |
| sda_low_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Failure flag, valid with `done_o` |

## Verification
Two outcomes can meet in one acknowledge slot: the poll counter reaching its limit and the target finally acknowledging. The bench models a target that refuses exactly `MAX_POLLS-1` polls and then acknowledges; this must end in success, with `MAX_POLLS` polls counted on the bus. A second target refuses all `MAX_POLLS` polls; this must end in an error after the same number of STARTs. A further case places a fresh request in the very clock of the `done_o` pulse, and the bench judges that no new START follows on the bus.

// File: rtl/i2cwp_pkg.sv
package i2cwp_pkg;
  localparam int unsigned DEV_W  = 7;
  localparam int unsigned BYTE_W = DEV_W + 1;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_BYTE  = 2'd1,
    CMD_STOP  = 2'd2
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_STA,
    ST_W_CTL,
    ST_W_ADR,
    ST_W_DAT,
    ST_W_STP,
    ST_P_STA,
    ST_P_CTL,
    ST_P_STP,
    ST_FIN
  } seq_st_e;
endpackage

// File: rtl/i2cwp_tick.sv
module i2cwp_tick #(
  parameter int unsigned QTR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  // counter held at zero while idle so the first quarter is full length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!en_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cwp_bus.sv
module i2cwp_bus
  import i2cwp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  bus_cmd_e          cmd_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              tick_i,
  input  logic              sda_i,
  output logic              act_o,
  output logic              done_o,
  output logic              ack_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam int unsigned BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] ACK_BIT = BCW'(BYTE_W);

  bus_cmd_e          op_q;
  logic              act_q, done_q, ack_q;
  logic [1:0]        qtr_q;
  logic [BCW-1:0]    bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              scl_low_q, sda_low_q;
  logic              scl_low_d, sda_low_d;
  logic              last_qtr, op_end;

  assign last_qtr = act_q && tick_i && (qtr_q == 2'd3);
  assign op_end   = last_qtr && ((op_q != CMD_BYTE) || (bit_q == ACK_BIT));

  // line pattern per quarter; SDA only moves with SCL high in START/STOP
  always_comb begin
    scl_low_d = 1'b0;
    sda_low_d = 1'b0;
    case (op_q)
      CMD_START: begin
        scl_low_d = (qtr_q == 2'd3);
        sda_low_d = (qtr_q != 2'd0);
      end
      CMD_BYTE: begin
        scl_low_d = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_low_d = (bit_q != ACK_BIT) && !sh_q[BYTE_W-1];
      end
      CMD_STOP: begin
        scl_low_d = (qtr_q == 2'd0);
        sda_low_d = (qtr_q < 2'd2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= CMD_START;
      act_q     <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      qtr_q     <= 2'd0;
      bit_q     <= '0;
      sh_q      <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      done_q <= op_end;
      if (!act_q) begin
        if (cmd_vld_i) begin
          act_q <= 1'b1;
          op_q  <= cmd_i;
          qtr_q <= 2'd0;
          bit_q <= '0;
          sh_q  <= byte_i;
        end
      end else if (tick_i) begin
        qtr_q <= qtr_q + 2'd1;
        if ((op_q == CMD_BYTE) && (bit_q == ACK_BIT) && (qtr_q == 2'd1))
          ack_q <= !sda_i;
        if (qtr_q == 2'd3) begin
          if (op_end) begin
            act_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
      // lines hold their last level between commands
      if (act_q) begin
        scl_low_q <= scl_low_d;
        sda_low_q <= sda_low_d;
      end
    end
  end

  assign act_o     = act_q;
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
endmodule

// File: rtl/i2cwp_seq.sv
module i2cwp_seq
  import i2cwp_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BYTE_W-1:0] wa_i,
  input  logic [BYTE_W-1:0] dat_i,
  input  logic              cmd_done_i,
  input  logic              ack_i,
  output logic              cmd_vld_o,
  output bus_cmd_e          cmd_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  seq_st_e           st_q, st_d;
  logic              issued_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] wa_q, dat_q;
  logic [PW-1:0]     polls_q;
  logic              fail_q, ok_q;
  logic              on_bus;

  assign on_bus    = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign cmd_vld_o = on_bus && !issued_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FIN);
  assign err_o     = done_o && fail_q;

  always_comb begin
    case (st_q)
      ST_W_STA, ST_P_STA: cmd_o = CMD_START;
      ST_W_STP, ST_P_STP: cmd_o = CMD_STOP;
      default:            cmd_o = CMD_BYTE;
    endcase
    case (st_q)
      ST_W_ADR: byte_o = wa_q;
      ST_W_DAT: byte_o = dat_q;
      default:  byte_o = {dev_q, 1'b0};
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req_i)      st_d = ST_W_STA;
      ST_W_STA: if (cmd_done_i) st_d = ST_W_CTL;
      ST_W_CTL: if (cmd_done_i) st_d = ack_i ? ST_W_ADR : ST_W_STP;
      ST_W_ADR: if (cmd_done_i) st_d = ack_i ? ST_W_DAT : ST_W_STP;
      ST_W_DAT: if (cmd_done_i) st_d = ST_W_STP;
      ST_W_STP: if (cmd_done_i) st_d = fail_q ? ST_FIN : ST_P_STA;
      ST_P_STA: if (cmd_done_i) st_d = ST_P_CTL;
      ST_P_CTL: if (cmd_done_i) st_d = ST_P_STP;
      ST_P_STP: if (cmd_done_i) st_d = (ok_q || fail_q) ? ST_FIN : ST_P_STA;
      ST_FIN:                   st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      dev_q    <= '0;
      wa_q     <= '0;
      dat_q    <= '0;
      polls_q  <= '0;
      fail_q   <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cmd_vld_o)       issued_q <= 1'b1;
      else if (cmd_done_i) issued_q <= 1'b0;
      if ((st_q == ST_IDLE) && req_i) begin
        dev_q   <= dev_i;
        wa_q    <= wa_i;
        dat_q   <= dat_i;
        polls_q <= '0;
        fail_q  <= 1'b0;
        ok_q    <= 1'b0;
      end
      if (cmd_done_i) begin
        case (st_q)
          ST_W_CTL, ST_W_ADR, ST_W_DAT: if (!ack_i) fail_q <= 1'b1;
          ST_P_CTL: begin
            polls_q <= polls_q + 1'b1;
            // acknowledge on the last permitted poll wins over the limit
            if (ack_i)                      ok_q   <= 1'b1;
            else if (polls_q == POLL_LAST)  fail_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_poll.sv
module i2c_wr_poll
  import i2cwp_pkg::*;
#(
  parameter int unsigned QTR_CYC   = 4,
  parameter int unsigned MAX_POLLS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [BYTE_W-1:0] word_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic              tick, bus_act, bus_done, bus_ack, cmd_vld;
  bus_cmd_e          cmd;
  logic [BYTE_W-1:0] cmd_byte;

  i2cwp_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bus_act),
    .tick_o (tick)
  );

  i2cwp_bus u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (cmd_vld),
    .cmd_i     (cmd),
    .byte_i    (cmd_byte),
    .tick_i    (tick),
    .sda_i     (sda_i),
    .act_o     (bus_act),
    .done_o    (bus_done),
    .ack_o     (bus_ack),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
  );

  i2cwp_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .dev_i      (dev_addr_i),
    .wa_i       (word_addr_i),
    .dat_i      (wr_data_i),
    .cmd_done_i (bus_done),
    .ack_i      (bus_ack),
    .cmd_vld_o  (cmd_vld),
    .cmd_o      (cmd),
    .byte_o     (cmd_byte),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/i2cwp_chk.sv
module i2cwp_chk #(
  parameter int unsigned MAX_POLLS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic scl_low_o,
  input logic sda_low_o
);
  localparam int unsigned SW = $clog2(MAX_POLLS + 3);
  localparam logic [SW-1:0] STA_MAX = SW'(MAX_POLLS + 1);

  logic scl_p, sda_p, free_q, sta_ev, sto_ev;
  logic [SW-1:0] sta_q;

  assign sta_ev = !scl_low_o && !scl_p && sda_low_o && !sda_p;
  assign sto_ev = !scl_low_o && !scl_p && !sda_low_o && sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p  <= 1'b0;
      sda_p  <= 1'b0;
      free_q <= 1'b0;
      sta_q  <= '0;
    end else begin
      scl_p <= scl_low_o;
      sda_p <= sda_low_o;
      if (sto_ev)      free_q <= 1'b1;
      else if (sta_ev) free_q <= 1'b0;
      if (!busy_o)                   sta_q <= '0;
      else if (sta_ev && sta_q != '1) sta_q <= sta_q + 1'b1;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_low_o && !sda_low_o)); // R1
  AST_REQ_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R2
  AST_BUS_FREE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q |-> !scl_low_o); // R4
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R7
  AST_POLL_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sta_q <= STA_MAX); // R8
  AST_ERR_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
endmodule

bind i2c_wr_poll i2cwp_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .scl_low_o (scl_low_o),
  .sda_low_o (sda_low_o)
);

// File: tb/tb_i2c_wr_poll.sv
module tb_i2c_wr_poll;
  localparam int QTR  = 4;
  localparam int MAXP = 8;
  localparam int WD   = 150000;
  localparam int NV   = 5;
  // {dev, word addr, data, refused polls, expected err}
  localparam logic [39:0] VEC [NV] = '{
    {8'h50, 8'h00, 8'hA5, 8'd0, 8'd0},
    {8'h51, 8'hFF, 8'h3C, 8'd3, 8'd0},
    {8'h7F, 8'h80, 8'h00, 8'd1, 8'd0},
    {8'h12, 8'h5E, 8'hE1, 8'd7, 8'd0},
    {8'h3D, 8'h01, 8'h96, 8'd8, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [6:0] dev = '0;
  logic [7:0] wa = '0, dat = '0;
  logic scl_low, sda_low, busy, done, err;
  logic tgt_low = 1'b0;
  wire  scl_w = !scl_low;
  wire  sda_w = !(sda_low || tgt_low);

  always #5 clk = ~clk;

  i2c_wr_poll #(.QTR_CYC(QTR), .MAX_POLLS(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .dev_addr_i(dev),
    .word_addr_i(wa), .wr_data_i(dat), .sda_i(sda_w),
    .scl_low_o(scl_low), .sda_low_o(sda_low),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  int seq_id = 0, arm_busy = 0, arm_nack = 3;

  // target model
  int starts = 0, stops = 0, polls = 0, bcnt = 0, bidx = 0, busy_left = 0, seen_id = -1;
  bit acking = 0, phase = 0, p_scl = 1, p_sda = 1, ack;
  logic [7:0] sh = '0, rx_ctl = '0, rx_wa = '0, rx_dat = '0, poll_ctl = '0;

  always @(scl_w or sda_w) begin
    if (scl_w && p_scl && !sda_w && p_sda) begin
      starts++; bcnt = 0; bidx = 0; acking = 0; tgt_low = 0;
      if (seq_id != seen_id) begin seen_id = seq_id; phase = 0; busy_left = arm_busy; end
    end else if (scl_w && p_scl && sda_w && !p_sda) begin
      stops++;
      if (!phase && bidx > 0) phase = 1;
    end else if (scl_w && !p_scl) begin
      if (bcnt < 8) begin sh = {sh[6:0], sda_w}; bcnt++; end
    end else if (!scl_w && p_scl) begin
      if (acking) begin
        tgt_low = 0; acking = 0; bcnt = 0; bidx++;
      end else if (bcnt == 8) begin
        if (bidx == 0) begin
          if (!phase) begin rx_ctl = sh; ack = (arm_nack != 0); end
          else begin
            poll_ctl = sh; polls++;
            if (busy_left > 0) begin ack = 0; busy_left--; end else ack = 1;
          end
        end else if (bidx == 1) begin rx_wa = sh; ack = (arm_nack != 1); end
        else begin rx_dat = sh; ack = (arm_nack != 2); end
        tgt_low = ack; acking = 1;
      end
    end
    p_scl = !scl_low;
    p_sda = !(sda_low || tgt_low);
  end

  // SCL high width of the first bit after each START
  int hi_cnt = 0, hi_w = 0, cap = 0;
  bit ps = 1, pd = 1;
  always @(posedge clk) begin
    cyc++;
    if (scl_w && ps && !sda_w && pd) cap = 2;
    if (scl_w) hi_cnt++;
    else begin
      if (ps) begin
        if (cap == 1) begin hi_w = hi_cnt; cap = 0; end
        else if (cap == 2) cap = 1;
      end
      hi_cnt = 0;
    end
    ps = scl_w; pd = sda_w;
  end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic [6:0] d, input logic [7:0] a, input logic [7:0] v,
                         input int bz, input int nk, input bit xerr,
                         input bit pk_busy, input bit pk_done, input bit chk_w);
    int s0, k0, p0, n, xs;
    bit e;
    s0 = starts; k0 = stops; p0 = polls; n = 0;
    xs = (nk < 3) ? 1 : ((bz < MAXP) ? bz + 2 : MAXP + 1);
    arm_busy = bz; arm_nack = nk; seq_id++;
    @(negedge clk); req = 1; dev = d; wa = a; dat = v;
    @(negedge clk); req = 0;
    chk(busy == 1, "R2", "busy after request", busy, 1);
    while (!done && cyc < WD) begin
      @(negedge clk); n++;
      if (pk_busy && n == 300) begin req = 1; dev = 7'h33; wa = 8'hEE; dat = 8'h99; end
      if (pk_busy && n == 301) req = 0;
    end
    chk(cyc < WD, "R7", "watchdog", cyc, WD);
    e = err;
    chk(e == xerr, "R7 R8 R9", "err with done", e, xerr);
    if (pk_done) begin req = 1; dev = 7'h11; wa = 8'h22; dat = 8'h33; end
    @(negedge clk); req = 0;
    chk(done == 0 && err == 0, "R10", "done/err one clock", {done, err}, 0);
    chk(busy == 0, "R7", "idle after done", busy, 0);
    chk(scl_low == 0 && sda_low == 0, "R1", "lines released", {scl_low, sda_low}, 0);
    chk(rx_ctl == {d, 1'b0}, "R3", "control byte", rx_ctl, {d, 1'b0});
    if (nk > 1) chk(rx_wa == a, "R3", "word address", rx_wa, a);
    if (nk > 2) chk(rx_dat == v, "R3", "data byte", rx_dat, v);
    chk(starts - s0 == xs, "R6 R8 R9", "START count", starts - s0, xs);
    chk(stops - k0 == starts - s0, "R6", "STOP per START", stops - k0, starts - s0);
    chk(polls - p0 == xs - 1, "R5 R6", "polls", polls - p0, xs - 1);
    if (xs > 1) chk(poll_ctl == {d, 1'b0}, "R6", "poll control byte", poll_ctl, {d, 1'b0});
    if (chk_w) chk(hi_w == 2 * QTR, "R4", "SCL high width", hi_w, 2 * QTR);
    s0 = starts;
    repeat (40) @(negedge clk);
    chk(busy == 0 && starts == s0, "R2", "no activity after sequence", starts - s0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !scl_low && !sda_low, "R1", "outputs in reset",
        {busy, done, err, scl_low, sda_low}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !err && !scl_low && !sda_low, "R1", "outputs after reset",
        {busy, done, err, scl_low, sda_low}, 0);
    for (int i = 0; i < NV; i++)
      run_seq(VEC[i][38:32], VEC[i][31:24], VEC[i][23:16], int'(VEC[i][15:8]), 3,
              VEC[i][0], 1'b0, 1'b0, i == 0);
    run_seq(7'h2A, 8'h10, 8'h77, 0, 1, 1'b1, 1'b0, 1'b0, 1'b0); // R9 word address refused
    run_seq(7'h2E, 8'h40, 8'h18, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0); // R9 control byte refused
    run_seq(7'h2B, 8'h20, 8'h5A, 2, 3, 1'b0, 1'b1, 1'b0, 1'b0); // R2 request while busy
    run_seq(7'h2C, 8'h30, 8'hC3, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0); // R2 request in done cycle
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule